// File: doc/BRIEF.md
# Timer and Interrupt Register Block

This byte-wide register block holds two 16-bit down-counters and the interrupt logic around them. Timer 1 has a 16-bit reload latch. The block also has a shift-data byte, an auxiliary control byte, and a flag and enable pair that combine into one interrupt line. A host reaches every register through a 4-bit address with separate read and write strobes. A counter advances only on cycles where the tick enable input is high. Writing one byte of a counter leaves the other byte of the live count unchanged.

Timer 1 counts down from the value loaded into it. When it passes zero, it reloads from its latch. In free-running mode, every such expiry raises the timer 1 flag. Timer 2 counts down and wraps around, and it raises no flag. An external shift-complete strobe raises the shift flag. A read of the shift-data byte lowers that flag again. The interrupt output is high while any enabled flag is set.

Top module: `timer_irq_regs`

## Requirements
- R1: After reset, both counters read 0xFFFF. The timer 1 latch reads 0x0000, which stands for a 65536-tick period. The auxiliary byte, the shift byte and all flags read 0. The enable register reads 0x44 (timer 1 enable at bit 6, shift enable at bit 2). `irq` is low.
- R2: A write to address 4 replaces the low byte of timer 1 and keeps its current high byte. A write to address 5 replaces the high byte and keeps the current low byte. Reads of addresses 4 and 5 return the live low and high bytes.
- R3: Addresses 8 and 9 write timer 2's low and high bytes under the same merge rule. Address 8 reads the low byte of the live count and address 9 reads the count shifted right by 8. Timer 2 wraps from 0 to 0xFFFF and sets no flag.
- R4: A counter decrements by one only on a clock where `tickEn` is high. A write to a counter in the same cycle takes precedence over the tick.
- R5: Addresses 6 and 7 write the low and high bytes of the timer 1 latch and read them back. On a tick while timer 1 is at 0, the counter loads (latch − 1) mod 65536. A loaded value N therefore expires on the (N+1)-th tick, and later expiries follow every latch ticks. A latch write takes effect at the next reload.
- R6: Address 11 is the auxiliary byte. Its bits 7:6 equal to 01 select free-running mode, and only in that mode does a timer 1 expiry set flag bit 6. In any other mode, timer 1 still reloads but sets no flag.
- R7: Address 10 writes and reads the shift byte. A read of address 10 clears flag bit 2. A high `shiftDone` sets flag bit 2, and a set in the same cycle wins over a clear.
- R8: A read of address 13 returns the flag register, with bit 7 equal to the OR of the flags whose enable is set. Writing 1 to bit 6 or bit 2 at address 13 clears that flag, and writing 0 leaves it unchanged.
- R9: A write to address 14 with bit 7 set sets the enable bits named by data bits 6 and 2. With bit 7 clear, the same write clears them instead. A read of address 14 returns the enables, with bit 7 reading 0.
- R10: `irq` is high exactly while flag and enable are both set at bit 6 or both set at bit 2.
- R11: `rdData` is 0 when `rdEn` is low and when the address is 0, 1, 2, 3, 12 or 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable, one tick per high cycle |
| shiftDone | input | 1 | Shift-complete strobe that sets the shift flag |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; a read of address 10 clears the shift flag at the clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from address and register state |
| irq | output | 1 | Interrupt request |

## Verification
Read data depends only on register state, so `rdData` is due in the same cycle that `rdEn` and `addr` are presented. A write, a tick, an expiry or a flag event changes register state at the next rising edge. The read data and `irq` that follow from it are therefore due in the cycle after. The bench drives inputs just after the falling edge and compares `rdData` and `irq` with its model a quarter period later, before the rising edge. It then advances the model with the inputs that the rising edge samples. Every result is thus checked in the first cycle in which it is due. Between directed accesses, the idle cycles read address 13, so flag changes and `irq` are compared on every clock.

// File: rtl/timer_irq_pkg.sv
package timer_irq_pkg;
  localparam int DATA_W = 8;

  localparam logic [3:0] A_T1LO = 4'd4;
  localparam logic [3:0] A_T1HI = 4'd5;
  localparam logic [3:0] A_L1LO = 4'd6;
  localparam logic [3:0] A_L1HI = 4'd7;
  localparam logic [3:0] A_T2LO = 4'd8;
  localparam logic [3:0] A_T2HI = 4'd9;
  localparam logic [3:0] A_SHDAT = 4'd10;
  localparam logic [3:0] A_AUX = 4'd11;
  localparam logic [3:0] A_FLAG = 4'd13;
  localparam logic [3:0] A_ENAB = 4'd14;

  localparam logic [DATA_W-1:0] BIT_T1 = 8'h40;
  localparam logic [DATA_W-1:0] BIT_SH = 8'h04;
  localparam logic [DATA_W-1:0] FLG_MASK = BIT_T1 | BIT_SH;
  localparam logic [1:0] MODE_FREE = 2'b01;

  typedef struct packed {
    logic t1Lo;
    logic t1Hi;
    logic l1Lo;
    logic l1Hi;
    logic t2Lo;
    logic t2Hi;
    logic shWr;
    logic auxWr;
    logic flgWr;
    logic enWr;
    logic shRd;
  } strobeT;
endpackage

// File: rtl/timer_irq_cnt.sv
module timer_irq_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         wrLo,
  input  logic         wrHi,
  input  logic [W/2-1:0] data,
  input  logic [W-1:0] reloadVal,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign expire = tick && !wrLo && !wrHi && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '1;
    else if (wrLo) count <= {count[W-1:HALF], data};
    else if (wrHi) count <= {data, count[HALF-1:0]};
    else if (tick) count <= expire ? reloadVal : count - ONE;
  end

  AST_MERGE_LO: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> count == {$past(count[W-1:HALF]), $past(data)}); // R2
  AST_MERGE_HI: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !wrLo) |=> count == {$past(data), $past(count[HALF-1:0])}); // R2
  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrLo && !wrHi && count != '0) |=> count == $past(count) - ONE); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrLo && !wrHi) |=> $stable(count)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> count == $past(reloadVal)); // R5
endmodule

// File: rtl/timer_irq_ctrl.sv
module timer_irq_ctrl
  import timer_irq_pkg::*;
(
  input  logic   [3:0] addr,
  input  logic         wrEn,
  input  logic         rdEn,
  output strobeT       stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (addr)
        A_T1LO:  stb.t1Lo = 1'b1;
        A_T1HI:  stb.t1Hi = 1'b1;
        A_L1LO:  stb.l1Lo = 1'b1;
        A_L1HI:  stb.l1Hi = 1'b1;
        A_T2LO:  stb.t2Lo = 1'b1;
        A_T2HI:  stb.t2Hi = 1'b1;
        A_SHDAT: stb.shWr = 1'b1;
        A_AUX:   stb.auxWr = 1'b1;
        A_FLAG:  stb.flgWr = 1'b1;
        A_ENAB:  stb.enWr = 1'b1;
        default: ;
      endcase
    end
    stb.shRd = rdEn && (addr == A_SHDAT);
  end
endmodule

// File: rtl/timer_irq_dp.sv
module timer_irq_dp
  import timer_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          shiftDone,
  input  strobeT        stb,
  input  logic [3:0]    addr,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          irq
);
  localparam int CNT_W = 2 * DW;
  localparam int N_TMR = 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] latchQ;
  logic [DW-1:0]    auxQ, shQ, flags, enables, pending;
  logic [DW-1:0]    flgSet, flgClr;
  logic             t1Hit, freeMode;

  logic [CNT_W-1:0] cntV [N_TMR];
  logic [CNT_W-1:0] reloadV [N_TMR];
  logic             wrLoV [N_TMR];
  logic             wrHiV [N_TMR];
  logic             expV [N_TMR];

  assign wrLoV[0] = stb.t1Lo;
  assign wrHiV[0] = stb.t1Hi;
  assign wrLoV[1] = stb.t2Lo;
  assign wrHiV[1] = stb.t2Hi;
  assign reloadV[0] = latchQ - ONE;
  assign reloadV[1] = '1;

  for (genvar g = 0; g < N_TMR; g++) begin : gTmr
    timer_irq_cnt #(.W(CNT_W)) i_cnt (
      .clk(clk), .rstN(rstN), .tick(tickEn),
      .wrLo(wrLoV[g]), .wrHi(wrHiV[g]), .data(wrData),
      .reloadVal(reloadV[g]), .count(cntV[g]), .expire(expV[g])
    );
  end

  assign freeMode = (auxQ[DW-1:DW-2] == MODE_FREE);
  assign t1Hit = expV[0] && freeMode;
  assign flgSet = ({DW{t1Hit}} & BIT_T1) | ({DW{shiftDone}} & BIT_SH);
  assign flgClr = (stb.flgWr ? wrData : '0) | (stb.shRd ? BIT_SH : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ  <= '0;
      auxQ    <= '0;
      shQ     <= '0;
      flags   <= '0;
      enables <= FLG_MASK;
    end else begin
      if (stb.l1Lo) latchQ[DW-1:0] <= wrData;
      if (stb.l1Hi) latchQ[CNT_W-1:DW] <= wrData;
      if (stb.auxWr) auxQ <= wrData;
      if (stb.shWr) shQ <= wrData;
      flags <= ((flags & ~flgClr) | flgSet) & FLG_MASK;
      if (stb.enWr)
        enables <= (wrData[DW-1] ? (enables | wrData) : (enables & ~wrData)) & FLG_MASK;
    end
  end

  assign pending = flags & enables;
  assign irq = |pending;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        A_T1LO:  rdData = cntV[0][DW-1:0];
        A_T1HI:  rdData = cntV[0][CNT_W-1:DW];
        A_L1LO:  rdData = latchQ[DW-1:0];
        A_L1HI:  rdData = latchQ[CNT_W-1:DW];
        A_T2LO:  rdData = cntV[1][DW-1:0];
        A_T2HI:  rdData = cntV[1][CNT_W-1:DW];
        A_SHDAT: rdData = shQ;
        A_AUX:   rdData = auxQ;
        A_FLAG:  rdData = {irq, flags[DW-2:0]};
        A_ENAB:  rdData = {1'b0, enables[DW-2:0]};
        default: rdData = '0;
      endcase
    end
  end

  AST_T1_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (expV[0] && freeMode) |=> flags[6]); // R6
  AST_T1_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[6] && !(expV[0] && freeMode)) |=> !flags[6]); // R6
  AST_T2_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (expV[1] && !expV[0] && !flags[6]) |=> !flags[6]); // R3
  AST_SH_RDCLR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shRd && !shiftDone) |=> !flags[2]); // R7
  AST_SH_SET: assert property (@(posedge clk) disable iff (!rstN)
    shiftDone |=> flags[2]); // R7
endmodule

// File: rtl/timer_irq_regs.sv
module timer_irq_regs
  import timer_irq_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          shiftDone,
  input  logic [3:0]    addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          irq
);
  strobeT stb;

  timer_irq_ctrl i_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  timer_irq_dp #(.DW(DW)) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .shiftDone(shiftDone),
    .stb(stb), .addr(addr), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/test_timer_irq_regs.sv
module test_timer_irq_regs;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, shiftDone = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irq;

  int vecs = 0, errs = 0;
  bit done = 0;
  string curReq = "R1";

  int mT1, mT2, mLatch, mAux, mSh, mFlg, mEn;

  always #(PER/2) clk = ~clk;

  timer_irq_regs i_timer_irq_regs (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .shiftDone(shiftDone),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  function automatic int expIrq();
    return ((mFlg & mEn & 8'h44) != 0) ? 1 : 0;
  endfunction

  function automatic int expRd();
    if (!rdEn) return 0;
    case (addr)
      4: return mT1 & 255;
      5: return (mT1 >> 8) & 255;
      6: return mLatch & 255;
      7: return (mLatch >> 8) & 255;
      8: return mT2 & 255;
      9: return (mT2 >> 8) & 255;
      10: return mSh;
      11: return mAux;
      13: return (expIrq() << 7) | mFlg;
      14: return mEn;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    mT1 = 16'hFFFF; mT2 = 16'hFFFF; mLatch = 65536;
    mAux = 0; mSh = 0; mFlg = 0; mEn = 8'h44;
  endtask

  task automatic modelStep();
    int d = wrData;
    bit w = wrEn;
    bit exp1 = 0;
    int clr = 0;
    if (w && addr == 4) mT1 = (mT1 & 16'hFF00) | d;
    else if (w && addr == 5) mT1 = (d << 8) | (mT1 & 255);
    else if (tickEn) begin
      if (mT1 == 0) begin
        exp1 = 1;
        mT1 = (mLatch - 1) & 16'hFFFF;
      end else mT1 = mT1 - 1;
    end
    if (w && addr == 8) mT2 = (mT2 & 16'hFF00) | d;
    else if (w && addr == 9) mT2 = (d << 8) | (mT2 & 255);
    else if (tickEn) mT2 = (mT2 == 0) ? 16'hFFFF : mT2 - 1;
    if (w && addr == 13) clr = d;
    if (rdEn && addr == 10) clr = clr | 8'h04;
    mFlg = mFlg & ~clr & 8'h44;
    if (exp1 && ((mAux >> 6) & 3) == 1) mFlg = mFlg | 8'h40;
    if (shiftDone) mFlg = mFlg | 8'h04;
    if (w && addr == 6) mLatch = (mLatch & 16'hFF00) | d;
    if (w && addr == 7) mLatch = (mLatch & 255) | (d << 8);
    if (w && addr == 10) mSh = d;
    if (w && addr == 11) mAux = d;
    if (w && addr == 14) mEn = ((d & 128) ? (mEn | d) : (mEn & ~d)) & 8'h44;
  endtask

  task automatic cyc();
    int er, ei;
    #(PER/4);
    er = expRd();
    ei = expIrq();
    vecs++;
    if (rdData !== er[7:0]) begin
      errs++;
      $display("FAIL %s addr=%0d rdData actual=%h expected=%h", curReq, addr, rdData, er[7:0]);
    end
    vecs++;
    if (irq !== ei[0]) begin
      errs++;
      $display("FAIL %s irq actual=%b expected=%b", curReq, irq, ei[0]);
    end
    @(posedge clk);
    modelStep();
    @(negedge clk);
    wrEn = 0; rdEn = 1; addr = 4'd13; tickEn = 0; shiftDone = 0; wrData = 0;
  endtask

  task automatic wr(input int a, input int d, input bit t = 0);
    wrEn = 1; rdEn = 0; addr = a[3:0]; wrData = d[7:0]; tickEn = t;
    cyc();
  endtask

  task automatic rd(input int a);
    wrEn = 0; rdEn = 1; addr = a[3:0];
    cyc();
  endtask

  task automatic run(input int n, input int every = 1, input int a = 13);
    for (int i = 0; i < n; i++) begin
      rdEn = 1; addr = a[3:0]; tickEn = ((i % every) == 0);
      cyc();
    end
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    rdEn = 1; addr = 4'd13;
    curReq = "R1";
    for (int a = 4; a <= 14; a++) if (a != 12) rd(a);
    curReq = "R11";
    rd(0); rd(1); rd(2); rd(3); rd(12); rd(15);
    rdEn = 0; addr = 4'd4; cyc();
    curReq = "R2";
    wr(4, 8'h34); rd(4); rd(5);
    wr(5, 8'h12); rd(4); rd(5);
    curReq = "R4";
    run(5, 1, 4); run(6, 3, 4);
    wr(4, 8'hAA, 1); rd(4); rd(5);
    run(3, 2, 5);
    curReq = "R3";
    wr(8, 8'h02); wr(9, 8'h00); rd(8); rd(9);
    run(4, 1, 8); rd(9); run(2, 1, 9);
    wr(9, 8'h5C, 1); rd(8); rd(9);
    curReq = "R5";
    wr(6, 8'h03); wr(7, 8'h00); rd(6); rd(7);
    wr(4, 8'h05); wr(5, 8'h00);
    curReq = "R6";
    wr(11, 8'h40); rd(11);
    curReq = "R5";
    run(14, 1, 13); run(3, 1, 4);
    curReq = "R8";
    wr(13, 8'h04); rd(13); wr(13, 8'h40); rd(13);
    curReq = "R5";
    wr(6, 8'h06); run(14, 1, 13);
    curReq = "R6";
    wr(13, 8'h40); wr(11, 8'h00); wr(4, 8'h02); wr(5, 8'h00);
    run(12, 1, 13);
    wr(11, 8'hC0); run(12, 1, 13);
    wr(11, 8'h80); run(10, 2, 13);
    curReq = "R7";
    wr(10, 8'h5A); rd(10);
    shiftDone = 1; cyc();
    rd(13); rd(10); rd(13);
    shiftDone = 1; rdEn = 1; addr = 4'd10; cyc(); rd(13);
    curReq = "R9";
    wr(14, 8'h04); rd(14); rd(13);
    curReq = "R10";
    run(2);
    curReq = "R9";
    wr(14, 8'h84); rd(14);
    curReq = "R10";
    run(2);
    curReq = "R9";
    wr(14, 8'h44); rd(14); wr(14, 8'hC4); rd(14);
    curReq = "R8";
    wr(13, 8'h00); rd(13); wr(13, 8'hFF); rd(13);
    curReq = "R10";
    wr(14, 8'h40); wr(11, 8'h40); wr(4, 8'h01); wr(5, 8'h00);
    run(4, 1, 13); wr(14, 8'hC0); run(2); wr(13, 8'h40); run(2);
    curReq = "R11";
    wr(12, 8'hFF); rd(12); wr(0, 8'h11); rd(0);
    rdEn = 0; addr = 4'd13; cyc();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(PER * 100000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule